// File: doc/BRIEF.md
# Condition-Field Mask/Mode Logic Unit

This unit is the execution stage for operations that move and combine data between a bank of eight 4-bit condition fields and a 64-bit integer operand. Every operation is built from one primitive. Each field bit k is tested against an expected value `mode[k]`, and the test only counts where `mask[k]` is set: `n_k = mask[k] & (mode[k] == actual[k])`. The four terms are then either kept as a nibble or reduced to a single bit, with AND when the M flag is 0 and OR when it is 1.

A 3-bit opcode selects one of six operations:
- single-bit reduce into an integer;
- nibble copy into an integer;
- two integer-to-field writes;
- masked field-to-field move with inversion;
- single-bit reduce into any bit of any field.

The whole condition bank is presented on a flat input. Field f occupies bits `[4f+3:4f]`, and field bit k sits at `4f+k`. The unit returns the value to write back, the field index and the write strobes one clock after the operation is presented with `op_valid`. It never stores the bank, so the surrounding pipeline performs the writes.

Top module: `cfu_unit`

## Requirements
- R1: Opcode 0 (reduce to integer) writes the integer result with bit 0 equal to the OR of n0..n3 when M=1 and the AND of n0..n3 when M=0, where the actual bits are those of field `src_field`; all other result bits are 0.
- R2: Opcode 1 (nibble copy) places n0 in integer bit 3, n1 in bit 2, n2 in bit 1 and n3 in bit 0, tested against field `src_field`; bits 63..4 are 0.
- R3: Opcode 2 (write field from integer bits) tests mode[k] against integer operand bit k and writes n0..n3 as field bits 0..3 of field `dst_field`.
- R4: Opcode 3 (write field from integer LSB) tests every mode bit against bit 0 of the operand, which is taken as 0 whenever `int_zero_sel` is 1. With zero operand, mask 1111 and mode equal to the inverse of a value V, it loads V. With M=1, mode 0000 sets the masked bits and mode 1111 clears them.
- R5: For opcodes 2, 3 and 4 with M=1, destination bits whose mask bit is 0 keep the old destination value; with M=0 those bits are 0 before any mode inversion.
- R6: Opcode 4 (masked move) writes `((mask & src) | (M ? old_dst & ~mask : 0)) ^ mode` into field `dst_field`.
- R7: Opcode 5 (reduce to bit) uses `bit_target[2:0]` as the field index and `bit_target[4:3]` as the bit index. It writes the reduction of R1 into that one bit and leaves the other three bits of that field at their old values.
- R8: When `rec_flag` is 1 on opcode 0 or 1, `rec_we` is asserted and `rec_value` holds bit 0 = result bit 63 (negative), bit 1 = result positive, bit 2 = result zero and bit 3 = `sticky_ov`. On field-writing opcodes `rec_we` stays 0.
- R9: Field-writing opcodes assert only `fld_we`, and integer-writing opcodes assert only `int_we`. Opcodes 6 and 7 and cycles with `op_valid` = 0 assert no strobe.
- R10: Results appear on the outputs one clock after the operation is presented. While `rst_n` is low at a clock edge, all outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation presented this cycle |
| opcode | input | 3 | Operation select (0..5; 6, 7 do nothing) |
| mask | input | 4 | Per-bit test enable |
| mode | input | 4 | Per-bit expected value / inversion pattern |
| m_flag | input | 1 | OR-reduce / keep-unmasked when 1 |
| rec_flag | input | 1 | Produce status field for integer results |
| src_field | input | 3 | Source field index |
| dst_field | input | 3 | Destination field index (opcodes 2..4) |
| bit_target | input | 5 | Bit and field target for opcode 5 |
| int_zero_sel | input | 1 | Treat integer operand as zero (opcode 3) |
| int_operand | input | 64 | Integer source operand |
| sticky_ov | input | 1 | Sticky overflow for the status field |
| fields_in | input | 32 | Current contents of all eight fields |
| int_result | output | 64 | Integer value to write |
| int_we | output | 1 | Integer write strobe |
| fld_idx | output | 3 | Index of field to write |
| fld_value | output | 4 | Field value to write |
| fld_we | output | 1 | Field write strobe |
| rec_we | output | 1 | Status field (field 0) write strobe |
| rec_value | output | 4 | Status field value |

## Verification
Each of the four actual-bit sources is driven with asymmetric field and operand patterns, such as 1010 against a mode of 0011. A swapped bit order or a wrong compare polarity then gives a different value from the expected one. Reductions are tried where all terms match, where exactly one term fails, and with an all-zero mask, which separates AND from OR. Write and move operations are run with M at both values on destinations whose unmasked bits differ from the new bits, so keeping and clearing are visible. The two bit-target cases use different fields and bit positions, which exposes a swap of the field and bit subfields.

// File: rtl/cfu_pkg.sv
// Shared opcode encoding for the condition-field logic unit.
// Assumes a 3-bit opcode; values 6 and 7 are reserved and produce no write.
package cfu_pkg;

    typedef enum logic [2:0] {
        OP_REDUCE_INT = 3'd0,
        OP_NIBBLE_INT = 3'd1,
        OP_FLD_BITS   = 3'd2,
        OP_FLD_LSB    = 3'd3,
        OP_MOVE       = 3'd4,
        OP_REDUCE_BIT = 3'd5,
        OP_RSVD6      = 3'd6,
        OP_RSVD7      = 3'd7
    } cfu_op_e;

    // Bit positions inside the status field produced by the record flag.
    localparam int REC_NEG  = 0;
    localparam int REC_POS  = 1;
    localparam int REC_ZERO = 2;
    localparam int REC_OV   = 3;

endpackage

// File: rtl/cfu_field_mux.sv
// Selects one field out of a flat bank of equally sized fields.
// Assumes field f occupies bits [f*FIELD_W +: FIELD_W] of the bank.
module cfu_field_mux #(
    parameter int NUM_FIELDS = 8,
    parameter int FIELD_W    = 4,
    localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
    input  logic [NUM_FIELDS*FIELD_W-1:0] bank,
    input  logic [SEL_W-1:0]              sel,
    output logic [FIELD_W-1:0]            field
);

    logic [FIELD_W-1:0] slot [NUM_FIELDS];

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_slot
        assign slot[f] = bank[f*FIELD_W +: FIELD_W];
    end

    // Index the unpacked view of the bank.
    always_comb begin
        field = slot[sel];
    end

endmodule

// File: rtl/cfu_test_terms.sv
// Per-bit masked equality test and its two reductions.
// Assumes the caller has already chosen which actual bits are tested.
module cfu_test_terms #(
    parameter int FIELD_W = 4
) (
    input  logic [FIELD_W-1:0] mask,
    input  logic [FIELD_W-1:0] expect_bits,
    input  logic [FIELD_W-1:0] actual,
    input  logic               use_or,
    output logic [FIELD_W-1:0] terms,
    output logic               reduced
);

    for (genvar k = 0; k < FIELD_W; k++) begin : g_term
        assign terms[k] = mask[k] & (expect_bits[k] == actual[k]);
    end

    // Collapse the terms with OR or AND as selected.
    always_comb begin
        reduced = use_or ? (|terms) : (&terms);
    end

endmodule

// File: rtl/cfu_status.sv
// Builds the status field for an integer result: sign, positive, zero, sticky overflow.
// Assumes a two's complement result whose top bit is the sign.
module cfu_status #(
    parameter int INT_W   = 64,
    parameter int FIELD_W = 4
) (
    input  logic [INT_W-1:0]   value,
    input  logic               sticky_ov,
    output logic [FIELD_W-1:0] status
);

    import cfu_pkg::*;

    // Classify the value and append the sticky overflow.
    always_comb begin
        status           = '0;
        status[REC_NEG]  = value[INT_W-1];
        status[REC_POS]  = ~value[INT_W-1] & (|value);
        status[REC_ZERO] = ~(|value);
        status[REC_OV]   = sticky_ov;
    end

endmodule

// File: rtl/cfu_unit.sv
// Condition-field mask/mode logic unit: six operations between a field bank
// and an integer operand, results registered once.
// Assumes the caller owns the field bank and performs the writes indicated.
module cfu_unit #(
    parameter int INT_W      = 64,
    parameter int NUM_FIELDS = 8,
    parameter int FIELD_W    = 4,
    localparam int SEL_W     = $clog2(NUM_FIELDS),
    localparam int BIT_W     = $clog2(FIELD_W),
    localparam int TGT_W     = SEL_W + BIT_W,
    localparam int BANK_W    = NUM_FIELDS * FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [2:0]         opcode,
    input  logic [FIELD_W-1:0] mask,
    input  logic [FIELD_W-1:0] mode,
    input  logic               m_flag,
    input  logic               rec_flag,
    input  logic [SEL_W-1:0]   src_field,
    input  logic [SEL_W-1:0]   dst_field,
    input  logic [TGT_W-1:0]   bit_target,
    input  logic               int_zero_sel,
    input  logic [INT_W-1:0]   int_operand,
    input  logic               sticky_ov,
    input  logic [BANK_W-1:0]  fields_in,
    output logic [INT_W-1:0]   int_result,
    output logic               int_we,
    output logic [SEL_W-1:0]   fld_idx,
    output logic [FIELD_W-1:0] fld_value,
    output logic               fld_we,
    output logic               rec_we,
    output logic [FIELD_W-1:0] rec_value
);

    import cfu_pkg::*;

    cfu_op_e            op;
    logic [FIELD_W-1:0] src_val;
    logic [FIELD_W-1:0] dst_val;
    logic [SEL_W-1:0]   dst_sel;
    logic [FIELD_W-1:0] actual;
    logic [FIELD_W-1:0] terms;
    logic               reduced;
    logic [FIELD_W-1:0] kept;
    logic [BIT_W-1:0]   tgt_bit;
    logic               lsb;

    logic [INT_W-1:0]   int_nx;
    logic               int_we_nx;
    logic [SEL_W-1:0]   idx_nx;
    logic [FIELD_W-1:0] fld_nx;
    logic               fld_we_nx;
    logic [FIELD_W-1:0] status_nx;

    assign op      = cfu_op_e'(opcode);
    assign tgt_bit = bit_target[TGT_W-1 -: BIT_W];
    assign lsb     = int_zero_sel ? 1'b0 : int_operand[0];

    // Destination field: the bit target's field for reduce-to-bit, else dst_field.
    always_comb begin
        dst_sel = (op == OP_REDUCE_BIT) ? bit_target[SEL_W-1:0] : dst_field;
    end

    cfu_field_mux #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_src_mux (
        .bank  (fields_in),
        .sel   (src_field),
        .field (src_val)
    );

    cfu_field_mux #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_dst_mux (
        .bank  (fields_in),
        .sel   (dst_sel),
        .field (dst_val)
    );

    // Pick the bits under test for the current opcode.
    always_comb begin
        case (op)
            OP_FLD_BITS: actual = int_operand[FIELD_W-1:0];
            OP_FLD_LSB:  actual = {FIELD_W{lsb}};
            default:     actual = src_val;
        endcase
    end

    cfu_test_terms #(.FIELD_W(FIELD_W)) u_terms (
        .mask        (mask),
        .expect_bits (mode),
        .actual      (actual),
        .use_or      (m_flag),
        .terms       (terms),
        .reduced     (reduced)
    );

    // Unmasked destination bits survive only in read-modify-write form.
    always_comb begin
        kept = m_flag ? (dst_val & ~mask) : '0;
    end

    // Form the next integer and field results and their strobes.
    always_comb begin
        int_nx    = '0;
        int_we_nx = 1'b0;
        idx_nx    = dst_sel;
        fld_nx    = '0;
        fld_we_nx = 1'b0;
        case (op)
            OP_REDUCE_INT: begin
                int_nx[0] = reduced;
                int_we_nx = 1'b1;
            end
            OP_NIBBLE_INT: begin
                for (int k = 0; k < FIELD_W; k++) begin
                    int_nx[FIELD_W-1-k] = terms[k];
                end
                int_we_nx = 1'b1;
            end
            OP_FLD_BITS, OP_FLD_LSB: begin
                fld_nx    = terms | kept;
                fld_we_nx = 1'b1;
            end
            OP_MOVE: begin
                fld_nx    = ((mask & src_val) | kept) ^ mode;
                fld_we_nx = 1'b1;
            end
            OP_REDUCE_BIT: begin
                fld_nx          = dst_val;
                fld_nx[tgt_bit] = reduced;
                fld_we_nx       = 1'b1;
            end
            default: begin
                int_we_nx = 1'b0;
                fld_we_nx = 1'b0;
            end
        endcase
    end

    cfu_status #(.INT_W(INT_W), .FIELD_W(FIELD_W)) u_status (
        .value     (int_nx),
        .sticky_ov (sticky_ov),
        .status    (status_nx)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_result <= '0;
            int_we     <= 1'b0;
            fld_idx    <= '0;
            fld_value  <= '0;
            fld_we     <= 1'b0;
            rec_we     <= 1'b0;
            rec_value  <= '0;
        end else begin
            int_result <= int_nx;
            int_we     <= op_valid & int_we_nx;
            fld_idx    <= idx_nx;
            fld_value  <= fld_nx;
            fld_we     <= op_valid & fld_we_nx;
            rec_we     <= op_valid & int_we_nx & rec_flag;
            rec_value  <= status_nx;
        end
    end

endmodule

// File: rtl/cfu_unit_chk.sv
// Protocol checks on the registered outputs of cfu_unit.
// Assumes it is bound to cfu_unit and sees its ports.
module cfu_unit_chk #(
    parameter int INT_W   = 64,
    parameter int FIELD_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic [INT_W-1:0]   int_result,
    input logic               int_we,
    input logic               fld_we,
    input logic               rec_we,
    input logic [FIELD_W-1:0] rec_value
);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_we && fld_we));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!int_we && !fld_we && !rec_we));

    // R2
    int_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_we |-> (int_result[INT_W-1:FIELD_W] == '0));

    // R8
    rec_needs_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_we |-> int_we);

    // R8
    rec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_we |-> (rec_value[2] == (int_result == '0)));

endmodule

bind cfu_unit cfu_unit_chk #(.INT_W(INT_W), .FIELD_W(FIELD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .int_result (int_result),
    .int_we     (int_we),
    .fld_we     (fld_we),
    .rec_we     (rec_we),
    .rec_value  (rec_value)
);

// File: tb/cfu_unit_test.sv
`timescale 1ns/1ps
// Directed bench for cfu_unit: one task per scenario, each checking its results.
module cfu_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  opcode = '0;
    logic [3:0]  mask = '0;
    logic [3:0]  mode = '0;
    logic        m_flag = 1'b0;
    logic        rec_flag = 1'b0;
    logic [2:0]  src_field = '0;
    logic [2:0]  dst_field = '0;
    logic [4:0]  bit_target = '0;
    logic        int_zero_sel = 1'b0;
    logic [63:0] int_operand = '0;
    logic        sticky_ov = 1'b0;
    // Fields 7..0 = 7,6,5,4,3,A,1,C
    logic [31:0] fields_in = 32'h7654_3A1C;
    logic [63:0] int_result;
    logic        int_we;
    logic [2:0]  fld_idx;
    logic [3:0]  fld_value;
    logic        fld_we;
    logic        rec_we;
    logic [3:0]  rec_value;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cfu_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .mask(mask), .mode(mode), .m_flag(m_flag), .rec_flag(rec_flag),
        .src_field(src_field), .dst_field(dst_field), .bit_target(bit_target),
        .int_zero_sel(int_zero_sel), .int_operand(int_operand),
        .sticky_ov(sticky_ov), .fields_in(fields_in),
        .int_result(int_result), .int_we(int_we), .fld_idx(fld_idx),
        .fld_value(fld_value), .fld_we(fld_we), .rec_we(rec_we),
        .rec_value(rec_value)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present one operation at a falling edge and sample one cycle later.
    task automatic issue(input logic [2:0] op, input logic [3:0] mk,
                         input logic [3:0] md, input logic m);
        @(negedge clk);
        op_valid = 1'b1;
        opcode   = op;
        mask     = mk;
        mode     = md;
        m_flag   = m;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R10", "int_we in reset", {63'd0, int_we}, 64'd0);
        check("R10", "fld_we in reset", {63'd0, fld_we}, 64'd0);
        check("R10", "result in reset", int_result, 64'd0);
    endtask

    task automatic t_reduce_int();
        src_field = 3'd2;  // 1010
        issue(3'd0, 4'b1111, 4'b1010, 1'b0);
        check("R1", "AND all match", int_result, 64'd1);
        check("R9", "int only", {62'd0, int_we, fld_we}, 64'd2);
        issue(3'd0, 4'b1111, 4'b1011, 1'b0);
        check("R1", "AND one miss", int_result, 64'd0);
        issue(3'd0, 4'b1111, 4'b1011, 1'b1);
        check("R1", "OR one miss", int_result, 64'd1);
        issue(3'd0, 4'b0000, 4'b1010, 1'b1);
        check("R1", "OR empty mask", int_result, 64'd0);
    endtask

    task automatic t_nibble();
        src_field = 3'd2;
        issue(3'd1, 4'b1111, 4'b0011, 1'b0);
        check("R2", "nibble mixed", int_result, 64'h6);
        issue(3'd1, 4'b0001, 4'b0000, 1'b0);
        check("R2", "n0 in bit3", int_result, 64'h8);
    endtask

    task automatic t_from_bits();
        int_operand = 64'hFFFF_0000_0000_0005;
        dst_field = 3'd3;
        issue(3'd2, 4'b1111, 4'b1111, 1'b0);
        check("R3", "from bits", {60'd0, fld_value}, 64'h5);
        check("R3", "index", {61'd0, fld_idx}, 64'd3);
        check("R9", "field only", {62'd0, int_we, fld_we}, 64'd1);
        dst_field = 3'd5;  // 0101
        issue(3'd2, 4'b0011, 4'b0000, 1'b1);
        check("R5", "M=1 keeps", {60'd0, fld_value}, 64'h6);
        issue(3'd2, 4'b0011, 4'b0000, 1'b0);
        check("R5", "M=0 clears", {60'd0, fld_value}, 64'h2);
    endtask

    task automatic t_from_lsb();
        int_operand = 64'h1;
        int_zero_sel = 1'b0;
        dst_field = 3'd4;
        issue(3'd3, 4'b1111, 4'b1100, 1'b0);
        check("R4", "lsb one", {60'd0, fld_value}, 64'hC);
        int_zero_sel = 1'b1;
        issue(3'd3, 4'b1111, 4'b1100, 1'b0);
        check("R4", "zero select", {60'd0, fld_value}, 64'h3);
        issue(3'd3, 4'b1111, 4'b1001, 1'b0);
        check("R4", "immediate load", {60'd0, fld_value}, 64'h6);
        dst_field = 3'd1;  // 0001
        issue(3'd3, 4'b0011, 4'b0000, 1'b1);
        check("R4", "set masked", {60'd0, fld_value}, 64'h3);
        dst_field = 3'd2;  // 1010
        issue(3'd3, 4'b0010, 4'b1111, 1'b1);
        check("R4", "clear masked", {60'd0, fld_value}, 64'h8);
        int_zero_sel = 1'b0;
    endtask

    task automatic t_move();
        src_field = 3'd2;  // 1010
        dst_field = 3'd0;  // 1100
        issue(3'd4, 4'b0110, 4'b0000, 1'b1);
        check("R6", "move rmw", {60'd0, fld_value}, 64'hA);
        issue(3'd4, 4'b0110, 4'b0000, 1'b0);
        check("R5", "move overwrite", {60'd0, fld_value}, 64'h2);
        issue(3'd4, 4'b0110, 4'b0011, 1'b1);
        check("R6", "move inverted", {60'd0, fld_value}, 64'h9);
        issue(3'd4, 4'b0000, 4'b0100, 1'b0);
        check("R6", "mode sets bit", {60'd0, fld_value}, 64'h4);
    endtask

    task automatic t_reduce_bit();
        src_field = 3'd2;
        bit_target = 5'b10_011;  // bit 2 of field 3 (0011)
        issue(3'd5, 4'b1111, 4'b1010, 1'b0);
        check("R7", "set one bit", {60'd0, fld_value}, 64'h7);
        check("R7", "target field", {61'd0, fld_idx}, 64'd3);
        bit_target = 5'b11_000;  // bit 3 of field 0 (1100)
        issue(3'd5, 4'b1111, 4'b1011, 1'b0);
        check("R7", "clear one bit", {60'd0, fld_value}, 64'h4);
        check("R7", "target field 0", {61'd0, fld_idx}, 64'd0);
    endtask

    task automatic t_record();
        src_field = 3'd2;
        rec_flag = 1'b1;
        sticky_ov = 1'b1;
        issue(3'd0, 4'b1111, 4'b1010, 1'b0);
        check("R8", "rec strobe", {63'd0, rec_we}, 64'd1);
        check("R8", "positive+ov", {60'd0, rec_value}, 64'hA);
        sticky_ov = 1'b0;
        issue(3'd1, 4'b0000, 4'b0000, 1'b0);
        check("R8", "zero", {60'd0, rec_value}, 64'h4);
        issue(3'd4, 4'b1111, 4'b0000, 1'b0);
        check("R8", "no rec on field op", {63'd0, rec_we}, 64'd0);
        rec_flag = 1'b0;
    endtask

    task automatic t_quiet();
        issue(3'd6, 4'b1111, 4'b0000, 1'b1);
        check("R9", "opcode 6", {61'd0, int_we, fld_we, rec_we}, 64'd0);
        issue(3'd7, 4'b1111, 4'b0000, 1'b1);
        check("R9", "opcode 7", {61'd0, int_we, fld_we, rec_we}, 64'd0);
        @(negedge clk);
        opcode = 3'd2;
        @(posedge clk);
        @(negedge clk);
        check("R9", "op_valid low", {61'd0, int_we, fld_we, rec_we}, 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reduce_int();
        t_nibble();
        t_from_bits();
        t_from_lsb();
        t_move();
        t_reduce_bit();
        t_record();
        t_quiet();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #20000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule